// File: doc/BRIEF.md
# Time Slot to Logical Channel Mapper

This block sits behind a channelized serial port and decides, bit by bit, which logical channel each serial bit belongs to. Every incoming bit comes with its time slot number and its bit position (0 to 7) inside that slot. A per-slot descriptor looks up the channel. The descriptor holds an enable flag, a 5-bit channel number and an 8-bit active mask. The block emits one registered record (valid, channel, data bit) for each bit it forwards.

A full mask gives a hyperchannel: all 8 bits of the slot go to one channel, and any set of slots, contiguous or not, can point at the same channel. A partial mask gives a subchannel: only the bits flagged in the mask are forwarded, and bits from several slots may be merged into one channel.

The receive and transmit paths each have their own stream and their own descriptor table. Both tables are loaded through one write port that carries a direction select. A write first lands in a pending copy. The working copy takes the pending contents on the first bit of the next frame, so one frame is never mapped with a mix of old and new settings.

Top module: `slot_chan_map`

## Requirements
- R1: After reset every descriptor in both directions is disabled, so no bit produces a valid record until a descriptor has been written and a frame boundary has passed.
- R2: When a bit is presented with `*_valid` high, its slot is enabled and mask bit `[*_bit]` of that slot is 1, the record appears one clock later: `*_out_valid` = 1, `*_out_chan` = the slot's channel, and `*_out_data` = the input bit.
- R3: A bit whose slot descriptor has the enable flag at 0 produces `*_out_valid` = 0, whatever its mask holds.
- R4: A bit whose position has a 0 in the slot's mask produces `*_out_valid` = 0. Only the positions set to 1 are forwarded, and two slots with partial masks may name the same channel.
- R5: A slot with mask 8'hFF forwards all 8 of its bits to its channel, and several non-adjacent slots may carry the same channel number.
- R6: A descriptor write takes effect from the first bit that has `*_frame_start` = 1 after the write. That bit itself is already mapped with the new settings. Bits before it, including later bits of the current frame, use the old settings.
- R7: `cfg_dir` = 0 writes the receive table and `cfg_dir` = 1 writes the transmit table. A write to one table leaves the mapping of the other direction unchanged.
- R8: A cycle with `*_valid` = 0 produces `*_out_valid` = 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_dir | input | 1 | Table select: 0 receive, 1 transmit |
| cfg_slot | input | SLOT_W | Slot whose descriptor is written |
| cfg_en | input | 1 | Slot enable flag |
| cfg_chan | input | 5 | Logical channel number 0 to 31 |
| cfg_mask | input | 8 | Active bit mask, bit i enables bit position i |
| rx_frame_start | input | 1 | Receive bit is the first bit of a frame |
| rx_valid | input | 1 | Receive bit present |
| rx_slot | input | SLOT_W | Receive bit slot number |
| rx_bit | input | 3 | Receive bit position within slot |
| rx_data | input | 1 | Receive data bit |
| rx_out_valid | output | 1 | Receive record valid |
| rx_out_chan | output | 5 | Receive record channel |
| rx_out_data | output | 1 | Receive record data bit |
| tx_frame_start | input | 1 | Transmit bit is the first bit of a frame |
| tx_valid | input | 1 | Transmit bit present |
| tx_slot | input | SLOT_W | Transmit bit slot number |
| tx_bit | input | 3 | Transmit bit position within slot |
| tx_data | input | 1 | Transmit data bit |
| tx_out_valid | output | 1 | Transmit record valid |
| tx_out_chan | output | 5 | Transmit record channel |
| tx_out_data | output | 1 | Transmit record data bit |

## Verification
The bench builds the block with NUM_SLOTS = 8, which gives a 3-bit slot index and a 64-bit frame. At that size every slot and every bit position of a frame can be checked one by one against a model of the pending and working tables, and several whole frames fit in a short run. That frame length also lets a descriptor be rewritten halfway through a frame, so the bench can show the old mapping holding until the next frame-start bit. Channel numbers at both ends of the range (0 and 31) and masks with scattered set bits are used, together with a transmit table configured differently from the receive table.

// File: rtl/slot_map_pkg.sv
package slot_map_pkg;
    localparam int CHAN_W        = 5;
    localparam int BITS_PER_SLOT = 8;
    localparam int BIT_IDX_W     = $clog2(BITS_PER_SLOT);
    localparam int NUM_DIRS      = 2;

    typedef struct packed {
        logic                     en;
        logic [CHAN_W-1:0]        chan;
        logic [BITS_PER_SLOT-1:0] mask;
    } slot_desc_t;
endpackage

// File: rtl/slot_desc_table.sv
module slot_desc_table
    import slot_map_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  slot_desc_t        wr_desc,
    input  logic              swap,
    input  logic [SLOT_W-1:0] rd_slot,
    output slot_desc_t        rd_desc
);
    typedef struct packed {
        slot_desc_t [NUM_SLOTS-1:0] pend;
        slot_desc_t [NUM_SLOTS-1:0] work;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (swap)  tbl_d.work          = tbl_q.pend;
        if (wr_en) tbl_d.pend[wr_slot] = wr_desc;
        // The frame-start bit already sees the pending contents.
        rd_desc = swap ? tbl_q.pend[rd_slot] : tbl_q.work[rd_slot];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // Working table only moves on a frame boundary.
    assert_work_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(tbl_q.work));
    // A swap loads exactly the pending contents seen at the boundary.
    assert_work_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> tbl_q.work == $past(tbl_q.pend));
endmodule

// File: rtl/slot_bit_mapper.sv
module slot_bit_mapper
    import slot_map_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_data,
    input  logic [BIT_IDX_W-1:0] in_bit,
    input  slot_desc_t           desc,
    output logic                 out_valid,
    output logic [CHAN_W-1:0]    out_chan,
    output logic                 out_data
);
    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic              data;
    } rec_t;

    rec_t rec_d, rec_q;
    logic hit;

    always_comb begin
        hit         = in_valid && desc.en && desc.mask[in_bit];
        rec_d.valid = hit;
        rec_d.chan  = hit ? desc.chan : '0;
        rec_d.data  = hit ? in_data   : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign out_valid = rec_q.valid;
    assign out_chan  = rec_q.chan;
    assign out_data  = rec_q.data;

    assert_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && desc.en && desc.mask[in_bit]) |=>
            (out_valid && out_chan == $past(desc.chan) && out_data == $past(in_data)));
    assert_disabled_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !desc.en) |=> !out_valid);
    assert_mask_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !desc.mask[in_bit]) |=> !out_valid);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/slot_dir_path.sv
module slot_dir_path
    import slot_map_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  slot_desc_t           wr_desc,
    input  logic                 frame_start,
    input  logic                 in_valid,
    input  logic [SLOT_W-1:0]    in_slot,
    input  logic [BIT_IDX_W-1:0] in_bit,
    input  logic                 in_data,
    output logic                 out_valid,
    output logic [CHAN_W-1:0]    out_chan,
    output logic                 out_data
);
    slot_desc_t cur_desc;
    logic       swap;

    assign swap = frame_start && in_valid;

    slot_desc_table #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_desc (wr_desc),
        .swap    (swap),
        .rd_slot (in_slot),
        .rd_desc (cur_desc)
    );

    slot_bit_mapper u_mapper (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_bit    (in_bit),
        .desc      (cur_desc),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .out_data  (out_data)
    );
endmodule

// File: rtl/slot_chan_map.sv
module slot_chan_map
    import slot_map_pkg::*;
#(
    parameter  int NUM_SLOTS = 32,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_dir,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_en,
    input  logic [4:0]        cfg_chan,
    input  logic [7:0]        cfg_mask,
    input  logic              rx_frame_start,
    input  logic              rx_valid,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [2:0]        rx_bit,
    input  logic              rx_data,
    output logic              rx_out_valid,
    output logic [4:0]        rx_out_chan,
    output logic              rx_out_data,
    input  logic              tx_frame_start,
    input  logic              tx_valid,
    input  logic [SLOT_W-1:0] tx_slot,
    input  logic [2:0]        tx_bit,
    input  logic              tx_data,
    output logic              tx_out_valid,
    output logic [4:0]        tx_out_chan,
    output logic              tx_out_data
);
    slot_desc_t                 cfg_desc;
    logic [NUM_DIRS-1:0]        fs_a, vl_a, dat_a, ov_a, od_a;
    logic [SLOT_W-1:0]          slot_a [NUM_DIRS];
    logic [BIT_IDX_W-1:0]       bit_a  [NUM_DIRS];
    logic [CHAN_W-1:0]          oc_a   [NUM_DIRS];

    assign cfg_desc = '{en: cfg_en, chan: cfg_chan, mask: cfg_mask};

    assign fs_a   = {tx_frame_start, rx_frame_start};
    assign vl_a   = {tx_valid, rx_valid};
    assign dat_a  = {tx_data, rx_data};
    assign slot_a[0] = rx_slot;
    assign slot_a[1] = tx_slot;
    assign bit_a[0]  = rx_bit;
    assign bit_a[1]  = tx_bit;

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
        slot_dir_path #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_path (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (cfg_we && (cfg_dir == d[0])),
            .wr_slot     (cfg_slot),
            .wr_desc     (cfg_desc),
            .frame_start (fs_a[d]),
            .in_valid    (vl_a[d]),
            .in_slot     (slot_a[d]),
            .in_bit      (bit_a[d]),
            .in_data     (dat_a[d]),
            .out_valid   (ov_a[d]),
            .out_chan    (oc_a[d]),
            .out_data    (od_a[d])
        );
    end

    assign rx_out_valid = ov_a[0];
    assign rx_out_chan  = oc_a[0];
    assign rx_out_data  = od_a[0];
    assign tx_out_valid = ov_a[1];
    assign tx_out_chan  = oc_a[1];
    assign tx_out_data  = od_a[1];

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rx_out_valid && !tx_out_valid));
endmodule

// File: tb/slot_chan_map_tb.sv
module slot_chan_map_tb;
    localparam int CLK_P = 10;
    localparam int NS    = 8;
    localparam int SW    = $clog2(NS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_dir = 0, cfg_en = 0;
    logic [SW-1:0] cfg_slot = '0;
    logic [4:0] cfg_chan = '0;
    logic [7:0] cfg_mask = '0;
    logic rx_fs = 0, rx_v = 0, rx_d = 0, tx_fs = 0, tx_v = 0, tx_d = 0;
    logic [SW-1:0] rx_s = '0, tx_s = '0;
    logic [2:0] rx_b = '0, tx_b = '0;
    logic rx_ov, rx_od, tx_ov, tx_od;
    logic [4:0] rx_oc, tx_oc;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model: {en, chan[4:0], mask[7:0]}
    bit [13:0] pend [2][NS];
    bit [13:0] cur  [2][NS];

    always #(CLK_P/2) clk = ~clk;

    slot_chan_map #(.NUM_SLOTS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_slot(cfg_slot),
        .cfg_en(cfg_en), .cfg_chan(cfg_chan), .cfg_mask(cfg_mask),
        .rx_frame_start(rx_fs), .rx_valid(rx_v), .rx_slot(rx_s), .rx_bit(rx_b), .rx_data(rx_d),
        .rx_out_valid(rx_ov), .rx_out_chan(rx_oc), .rx_out_data(rx_od),
        .tx_frame_start(tx_fs), .tx_valid(tx_v), .tx_slot(tx_s), .tx_bit(tx_b), .tx_data(tx_d),
        .tx_out_valid(tx_ov), .tx_out_chan(tx_oc), .tx_out_data(tx_od)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(int d, int s, bit en, int ch, int m);
        @(negedge clk);
        cfg_we = 1; cfg_dir = d[0]; cfg_slot = s[SW-1:0];
        cfg_en = en; cfg_chan = ch[4:0]; cfg_mask = m[7:0];
        @(posedge clk);
        #(CLK_P/4);
        cfg_we = 0;
        pend[d][s] = {en, ch[4:0], m[7:0]};
    endtask

    // Present one bit, then compare the record one clock later.
    task automatic push_bit(int d, bit fs, int s, int b, bit dat, string tag);
        bit [13:0] dsc;
        bit ev;
        @(negedge clk);
        if (d == 0) begin rx_fs = fs; rx_v = 1; rx_s = s[SW-1:0]; rx_b = b[2:0]; rx_d = dat; end
        else        begin tx_fs = fs; tx_v = 1; tx_s = s[SW-1:0]; tx_b = b[2:0]; tx_d = dat; end
        if (fs) for (int k = 0; k < NS; k++) cur[d][k] = pend[d][k];
        dsc = cur[d][s];
        ev  = dsc[13] && dsc[b];
        @(posedge clk);
        #(CLK_P/4);
        if (d == 0) begin
            check(tag, "rx_out_valid", rx_ov, ev);
            if (ev) begin
                check(tag, "rx_out_chan", rx_oc, dsc[12:8]);
                check(tag, "rx_out_data", rx_od, dat);
            end
            rx_v = 0; rx_fs = 0;
        end else begin
            check(tag, "tx_out_valid", tx_ov, ev);
            if (ev) begin
                check(tag, "tx_out_chan", tx_oc, dsc[12:8]);
                check(tag, "tx_out_data", tx_od, dat);
            end
            tx_v = 0; tx_fs = 0;
        end
    endtask

    task automatic run_frame(int d, int seed, string tag);
        for (int s = 0; s < NS; s++)
            for (int b = 0; b < 8; b++)
                push_bit(d, (s == 0 && b == 0), s, b, bit'(((s * 5 + b * 3 + seed) >> 1) & 1), tag);
    endtask

    task automatic t_reset();
        check("R1", "rx_out_valid at reset", rx_ov, 0);
        check("R1", "tx_out_valid at reset", tx_ov, 0);
        run_frame(0, 1, "R1");
        run_frame(1, 2, "R1");
    endtask

    task automatic t_hyper();
        cfg_write(0, 1, 1, 9, 8'hFF);
        cfg_write(0, 4, 1, 9, 8'hFF);
        cfg_write(0, 6, 1, 9, 8'hFF);
        cfg_write(0, 2, 1, 31, 8'hFF);
        run_frame(0, 3, "R5");
        run_frame(0, 7, "R2");
    endtask

    task automatic t_sub();
        cfg_write(0, 3, 1, 0, 8'b1010_0101);
        cfg_write(0, 5, 1, 0, 8'b0101_0000);
        run_frame(0, 4, "R4");
    endtask

    task automatic t_disabled();
        cfg_write(0, 4, 0, 12, 8'hFF);
        run_frame(0, 5, "R3");
    endtask

    task automatic t_boundary();
        // slot 6 currently chan 9 mask FF; rewrite it mid-frame.
        for (int s = 0; s < NS; s++)
            for (int b = 0; b < 8; b++) begin
                if (s == 3 && b == 0) cfg_write(0, 6, 1, 20, 8'h0F);
                push_bit(0, (s == 0 && b == 0), s, b, bit'((s + b) & 1), "R6");
            end
        // Old setting still active: bit 7 of slot 6 was forwarded on chan 9.
        push_bit(0, 1, 6, 7, 1, "R6");
        check("R6", "new mask blocks bit 7 at boundary", rx_ov, 0);
        push_bit(0, 0, 6, 2, 1, "R6");
        check("R6", "new chan after boundary", rx_oc, 20);
    endtask

    task automatic t_indep();
        cfg_write(1, 0, 1, 17, 8'hC3);
        cfg_write(1, 6, 1, 31, 8'hFF);
        cfg_write(1, 2, 0, 5, 8'hFF);
        run_frame(1, 6, "R7");
        run_frame(0, 9, "R7");
        cfg_write(1, 6, 0, 0, 8'h00);
        run_frame(0, 2, "R7");
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_v = 0; tx_v = 0; rx_s = 3'd6; rx_b = 3'd2; rx_d = 1;
            @(posedge clk);
            #(CLK_P/4);
            check("R8", "rx_out_valid idle", rx_ov, 0);
            check("R8", "tx_out_valid idle", tx_ov, 0);
        end
    endtask

    initial begin
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < NS; s++) begin pend[d][s] = '0; cur[d][s] = '0; end
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        rst_n = 1;
        t_reset();
        t_hyper();
        t_sub();
        t_disabled();
        t_boundary();
        t_indep();
        t_idle();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule